// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block brings one secondary processor core from fully off to powered and running. Each core owns two control words. The power-control word carries the clamps, the memory head switch, the two resets and a powered-up flag. The power-gate word carries a head-switch enable and a head-switch count. A single start pulse, with a core index beside it, makes the block step that core's words through a fixed series of register updates. Three of those updates are followed by a timed settling wait.

The wait length comes from the clock frequency parameter: the frequency in MHz times two microseconds gives the cycle count. Every core's words appear on flat output buses. A small combinational read port also returns a word, chosen by core index and offset within that core's window. While a sequence runs, the block reports busy and ignores any further start. When the powered-up flag has been written, a one-cycle done pulse follows and the block goes back to idle.

Top module: `core_pwrup_seq`

## Requirements
- R1: A synchronous active-low reset clears every core's power-control and power-gate words to zero and drops busy and done, even in the middle of a sequence.
- R2: One clock after the start edge, the target power-control word becomes 0x33: output clamp (bit 0), memory clamp (bit 1), core reset (bit 4) and power-on reset (bit 5) set, all other bits clear.
- R3: One clock later, the target power-gate word becomes 0x1000_0001: head-switch enable at bit 0 and a count of 16 in the field starting at bit 24.
- R4: After the power-gate write, the power-control word stays unchanged for WAIT_CYC clocks. On the following clock, the memory clamp (bit 1) clears, giving 0x31.
- R5: One clock after the memory clamp clears, the memory head switch (bit 3) is set, giving 0x39. The word then holds for WAIT_CYC clocks, and on the next clock the output clamp (bit 0) clears, giving 0x38.
- R6: WAIT_CYC+1 clocks after the output clamp clears, the core reset and power-on reset clear together in one update, giving 0x08. One clock later, the powered-up flag (bit 7) is set, giving 0x88.
- R7: Busy is high from the clock after the start edge until the done cycle ends. Done is high for exactly the one cycle that follows the powered-up write. After that, busy is low.
- R8: A start request while busy, including during the done cycle, is ignored. It neither disturbs the running sequence nor touches the requested core.
- R9: A sequence changes only the registers of the indexed core. Every other core keeps its words.
- R10: The read port returns the selected core's power-control word at offset 0x04 and its power-gate word at offset 0x14. Any other offset, or a core index out of range, returns zero.
- R11: WAIT_CYC equals CLK_MHZ × 2. With the default 200 MHz this is 400 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to power up a core, sampled in idle |
| core_idx_i | input | IDX_W | Core to power up |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |
| pctl_o | output | NUM_CORES×32 | Power-control words, core 0 in the low 32 bits |
| gate_o | output | NUM_CORES×32 | Power-gate words, core 0 in the low 32 bits |
| rd_core_i | input | IDX_W | Read port core select |
| rd_off_i | input | 8 | Read port offset within the core window |
| rd_data_o | output | 32 | Read port data |

## Verification
Every internal fault in this block shows up on the target core's register outputs. A wrong step state lands a wrong bit pattern. A wrong wait counter moves an update off its exact clock. A wrong index decode writes the neighbouring core. The bench samples each word on the exact clock where an update must land, and also one clock before it. An ordering or timing error therefore becomes visible within one clock of the faulty step. A lost or stuck done pulse shows in the cycle after the final write.

// File: rtl/pwrup_pkg.sv
// Package: shared bit positions, window offsets and step encoding for the
// core power-up sequencer. Assumes 32-bit control words.
package pwrup_pkg;
    // Power-control word bit positions
    localparam int PB_OCLAMP   = 0;
    localparam int PB_MCLAMP   = 1;
    localparam int PB_L1RSTDIS = 2;
    localparam int PB_MEMHS    = 3;
    localparam int PB_CRST     = 4;
    localparam int PB_PORST    = 5;
    localparam int PB_CLKGATE  = 6;
    localparam int PB_PWRDUP   = 7;

    // Power-gate word fields
    localparam int GB_HSEN      = 0;
    localparam int GB_HSCNT_LSB = 24;

    // Offsets in a core's register window
    localparam logic [7:0] OFF_PCTL = 8'h04;
    localparam logic [7:0] OFF_GATE = 8'h14;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PCTL_INIT,
        ST_GATE_ON,
        ST_WAIT_GATE,
        ST_MCLAMP_OFF,
        ST_MEMHS_ON,
        ST_WAIT_MEMHS,
        ST_OCLAMP_OFF,
        ST_WAIT_OCLAMP,
        ST_RST_OFF,
        ST_PWRDUP,
        ST_DONE
    } step_e;
endpackage

// File: rtl/pwrup_delay.sv
// Module: settling-wait counter. A load pulse arms it for WAIT_CYC cycles.
// expired_o is high once the count has run down to zero.
// Assumes WAIT_CYC >= 1.
module pwrup_delay #(
    parameter int WAIT_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count down from the load value to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_VAL); // R11
    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/pwrup_fsm.sv
// Module: step sequencer. It walks the fixed power-up order and emits one
// register write per step. A shadow of the power-control word lets each
// step modify only its own bits. Assumes start_i is a single-cycle request.
module pwrup_fsm
    import pwrup_pkg::*;
#(
    parameter int IDX_W    = 2,
    parameter int HS_COUNT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] core_idx_i,
    input  logic             expired_i,
    output logic             load_wait_o,
    output logic             wr_pctl_o,
    output logic             wr_gate_o,
    output logic [31:0]      wr_data_o,
    output logic [IDX_W-1:0] tgt_core_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [31:0] GATE_VAL =
        (32'(HS_COUNT) << GB_HSCNT_LSB) | (32'd1 << GB_HSEN);

    step_e            st_q, st_d;
    logic [7:0]       shadow_q, shadow_d;
    logic [IDX_W-1:0] tgt_q;

    // State, shadow word and target core registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            shadow_q <= '0;
            tgt_q    <= '0;
        end else begin
            st_q     <= st_d;
            shadow_q <= shadow_d;
            if (st_q == ST_IDLE && start_i) tgt_q <= core_idx_i;
        end
    end

    // Next step, write strobes and the updated shadow word.
    always_comb begin
        st_d        = st_q;
        shadow_d    = shadow_q;
        load_wait_o = 1'b0;
        wr_pctl_o   = 1'b0;
        wr_gate_o   = 1'b0;
        wr_data_o   = '0;
        unique case (st_q)
            ST_IDLE: if (start_i) st_d = ST_PCTL_INIT;
            ST_PCTL_INIT: begin
                shadow_d = '0;
                shadow_d[PB_OCLAMP] = 1'b1;
                shadow_d[PB_MCLAMP] = 1'b1;
                shadow_d[PB_CRST]   = 1'b1;
                shadow_d[PB_PORST]  = 1'b1;
                wr_pctl_o = 1'b1;
                st_d = ST_GATE_ON;
            end
            ST_GATE_ON: begin
                wr_gate_o   = 1'b1;
                wr_data_o   = GATE_VAL;
                load_wait_o = 1'b1;
                st_d = ST_WAIT_GATE;
            end
            ST_WAIT_GATE: if (expired_i) st_d = ST_MCLAMP_OFF;
            ST_MCLAMP_OFF: begin
                shadow_d[PB_MCLAMP] = 1'b0;
                wr_pctl_o = 1'b1;
                st_d = ST_MEMHS_ON;
            end
            ST_MEMHS_ON: begin
                shadow_d[PB_MEMHS] = 1'b1;
                wr_pctl_o   = 1'b1;
                load_wait_o = 1'b1;
                st_d = ST_WAIT_MEMHS;
            end
            ST_WAIT_MEMHS: if (expired_i) st_d = ST_OCLAMP_OFF;
            ST_OCLAMP_OFF: begin
                shadow_d[PB_OCLAMP] = 1'b0;
                wr_pctl_o   = 1'b1;
                load_wait_o = 1'b1;
                st_d = ST_WAIT_OCLAMP;
            end
            ST_WAIT_OCLAMP: if (expired_i) st_d = ST_RST_OFF;
            ST_RST_OFF: begin
                shadow_d[PB_CRST]  = 1'b0;
                shadow_d[PB_PORST] = 1'b0;
                wr_pctl_o = 1'b1;
                st_d = ST_PWRDUP;
            end
            ST_PWRDUP: begin
                shadow_d[PB_PWRDUP] = 1'b1;
                wr_pctl_o = 1'b1;
                st_d = ST_DONE;
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
        if (wr_pctl_o) wr_data_o = {24'd0, shadow_d};
    end

    assign tgt_core_o = tgt_q;
    assign busy_o     = (st_q != ST_IDLE);
    assign done_o     = (st_q == ST_DONE);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(tgt_q)); // R8
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pctl_o && wr_gate_o)); // R2
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_GATE && !expired_i) |=> (st_q == ST_WAIT_GATE)); // R4
endmodule

// File: rtl/pwrup_regbank.sv
// Module: per-core register store. It holds one power-control word and one
// power-gate word for each core and applies writes from the sequencer.
// Indices at or above NUM_CORES write nothing.
module pwrup_regbank
    import pwrup_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_pctl_i,
    input  logic                      wr_gate_i,
    input  logic [31:0]               wr_data_i,
    input  logic [IDX_W-1:0]          tgt_core_i,
    output logic [NUM_CORES*32-1:0]   pctl_o,
    output logic [NUM_CORES*32-1:0]   gate_o
);
    logic [NUM_CORES-1:0] sel;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [31:0] pctl_q, gate_q;

        assign sel[c] = (tgt_core_i == IDX_W'(c));

        // Hold this core's words and apply addressed writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pctl_q <= '0;
                gate_q <= '0;
            end else begin
                if (wr_pctl_i && sel[c]) pctl_q <= wr_data_i;
                if (wr_gate_i && sel[c]) gate_q <= wr_data_i;
            end
        end

        assign pctl_o[c*32 +: 32] = pctl_q;
        assign gate_o[c*32 +: 32] = gate_q;

        AST_PWRUP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pctl_q[PB_PWRDUP]) |-> (pctl_q[PB_CRST] == 1'b0 && pctl_q[PB_PORST] == 1'b0)); // R6
        AST_CLAMP_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pctl_q[PB_MEMHS]) |-> !pctl_q[PB_MCLAMP]); // R5
    end

    AST_ONE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R9
endmodule

// File: rtl/core_pwrup_seq.sv
// Module: top of the secondary-core power-up sequencer. It ties together
// the step sequencer, the wait counter and the per-core register store,
// and it serves a combinational read port over each core's window.
// Assumes CLK_MHZ * 2 >= 1.
module core_pwrup_seq
    import pwrup_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int CLK_MHZ   = 200,
    parameter int WAIT_US   = 2,
    parameter int HS_COUNT  = 16,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [IDX_W-1:0]        core_idx_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [NUM_CORES*32-1:0] pctl_o,
    output logic [NUM_CORES*32-1:0] gate_o,
    input  logic [IDX_W-1:0]        rd_core_i,
    input  logic [7:0]              rd_off_i,
    output logic [31:0]             rd_data_o
);
    logic             load_wait, expired, wr_pctl, wr_gate;
    logic [31:0]      wr_data;
    logic [IDX_W-1:0] tgt_core;

    pwrup_fsm #(.IDX_W(IDX_W), .HS_COUNT(HS_COUNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .core_idx_i(core_idx_i),
        .expired_i(expired), .load_wait_o(load_wait), .wr_pctl_o(wr_pctl),
        .wr_gate_o(wr_gate), .wr_data_o(wr_data), .tgt_core_o(tgt_core),
        .busy_o(busy_o), .done_o(done_o)
    );

    pwrup_delay #(.WAIT_CYC(WAIT_CYC)) u_delay (
        .clk(clk), .rst_n(rst_n), .load_i(load_wait), .expired_o(expired)
    );

    pwrup_regbank #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_pctl_i(wr_pctl), .wr_gate_i(wr_gate),
        .wr_data_i(wr_data), .tgt_core_i(tgt_core), .pctl_o(pctl_o), .gate_o(gate_o)
    );

    // Read port: select a core's word by window offset.
    always_comb begin
        rd_data_o = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (rd_core_i == IDX_W'(c)) begin
                if (rd_off_i == OFF_PCTL)      rd_data_o = pctl_o[c*32 +: 32];
                else if (rd_off_i == OFF_GATE) rd_data_o = gate_o[c*32 +: 32];
            end
        end
    end

    AST_DONE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R7
endmodule

// File: tb/sim_core_pwrup_seq.sv
// Directed bench for the core power-up sequencer.
module sim_core_pwrup_seq;
    localparam int NC = 4;
    localparam int W  = 400;   // R11: 200 MHz * 2 us

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] idx = '0;
    logic busy, done;
    logic [NC*32-1:0] pctl, gate;
    logic [1:0] rd_core = '0;
    logic [7:0] rd_off = '0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    core_pwrup_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .core_idx_i(idx),
        .busy_o(busy), .done_o(done), .pctl_o(pctl), .gate_o(gate),
        .rd_core_i(rd_core), .rd_off_i(rd_off), .rd_data_o(rd_data)
    );

    function automatic logic [31:0] pc(int c); return pctl[c*32 +: 32]; endfunction
    function automatic logic [31:0] gw(int c); return gate[c*32 +: 32]; endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic adv(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(int c);
        start = 1'b1; idx = 2'(c);
        adv(1);
        start = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; adv(2); rst_n = 1'b1; adv(1);
    endtask

    // Full boot of core c, checking each update on its exact clock.
    // With intrude set, starts for core ic are raised while busy.
    task automatic boot_core(int c, bit intrude, int ic);
        pulse_start(c);                                     // after E0
        chk("R7 busy after start", {31'd0, busy}, 32'd1);
        adv(1);                                             // E1
        chk("R2 initial pctl", pc(c), 32'h33);
        chk("R3 gate not yet", gw(c), 32'h0);
        adv(1);                                             // E2
        chk("R3 gate word", gw(c), 32'h1000_0001);
        if (intrude) begin start = 1'b1; idx = 2'(ic); adv(1); start = 1'b0; adv(W - 1); end
        else adv(W);                                        // E402
        chk("R4 held during wait", pc(c), 32'h33);
        adv(1);                                             // E403
        chk("R4 mem clamp cleared", pc(c), 32'h31);
        adv(1);                                             // E404
        chk("R5 head switch on", pc(c), 32'h39);
        adv(W);                                             // E804
        chk("R5 held during wait", pc(c), 32'h39);
        adv(1);                                             // E805
        chk("R5 output clamp cleared", pc(c), 32'h38);
        adv(W);                                             // E1205
        chk("R6 held during wait", pc(c), 32'h38);
        adv(1);                                             // E1206
        chk("R6 resets cleared together", pc(c), 32'h08);
        chk("R7 no early done", {31'd0, done}, 32'd0);
        adv(1);                                             // E1207
        chk("R6 powered-up flag", pc(c), 32'h88);
        chk("R7 done pulse", {31'd0, done}, 32'd1);
        if (intrude) begin start = 1'b1; idx = 2'(ic); end
        adv(1);                                             // E1208
        start = 1'b0;
        chk("R7 done one cycle", {31'd0, done}, 32'd0);
        chk("R7 idle after done", {31'd0, busy}, 32'd0);
        chk("R3 gate kept", gw(c), 32'h1000_0001);
    endtask

    task automatic t_reset_state();
        do_reset();
        for (int c = 0; c < NC; c++) begin
            chk("R1 pctl zero", pc(c), 32'h0);
            chk("R1 gate zero", gw(c), 32'h0);
        end
        chk("R1 busy low", {31'd0, busy}, 32'd0);
        chk("R1 done low", {31'd0, done}, 32'd0);
    endtask

    task automatic t_boot_two();
        boot_core(0, 1'b0, 0);
        boot_core(2, 1'b0, 0);
        chk("R9 core0 kept pctl", pc(0), 32'h88);
        chk("R9 core1 untouched", pc(1), 32'h0);
        chk("R9 core3 untouched", gw(3), 32'h0);
    endtask

    task automatic t_busy_ignore();
        boot_core(1, 1'b1, 3);
        adv(2);
        chk("R8 no second sequence", {31'd0, busy}, 32'd0);
        chk("R8 core3 pctl untouched", pc(3), 32'h0);
        chk("R8 core3 gate untouched", gw(3), 32'h0);
    endtask

    task automatic t_readport();
        rd_core = 2'd1; rd_off = 8'h04; #1;
        chk("R10 pctl offset", rd_data, 32'h88);
        rd_off = 8'h14; #1;
        chk("R10 gate offset", rd_data, 32'h1000_0001);
        rd_off = 8'h08; #1;
        chk("R10 unmapped offset", rd_data, 32'h0);
        rd_core = 2'd3; rd_off = 8'h04; #1;
        chk("R10 other core", rd_data, 32'h0);
        adv(1);
    endtask

    task automatic t_mid_reset();
        pulse_start(3);
        adv(500);
        chk("R1 mid-run busy", {31'd0, busy}, 32'd1);
        do_reset();
        chk("R1 core3 cleared", pc(3), 32'h0);
        chk("R1 core1 cleared", pc(1), 32'h0);
        chk("R1 gate cleared", gw(1), 32'h0);
        chk("R1 busy cleared", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        t_reset_state();
        t_boot_two();
        t_busy_ignore();
        t_readport();
        t_mid_reset();
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule